// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block compares a 24-bit bus address against four programmable windows and reports which windows contain it. Each window has a start address and an 8-bit mask held in registers that are loaded through a one-cycle register-write port. A mask bit set to 1 removes its address bits from the compare, so the mask sets the window's size. Address bits above a window's maskable range are always compared. Each window has its own maskable range and its own mapping of mask bits to address bits.

Windows 0 and 1 compare at 256-byte granularity. In their masks one bit covers a whole run of middle address bits. Windows 2 and 3 compare at 32 KB granularity, with one mask bit per address bit. After reset window 2 answers for the entire 16 MB space until software sets its mapping bit. Windows 0, 1 and 3 stay silent until they are enabled. When windows overlap, a fixed priority reduces the raw matches to a single one-hot select.

The block has no data stream. The write port and the address input are plain control inputs with no back-pressure. A write is accepted in every cycle in which `wr_en` is high.

Top module: `csel_decoder`

## Requirements
- R1: After reset all start registers are 0x00, all mask registers are 0xFF and the control register is 0x0. With that state, `win_hit` is 4'b0100 and `cs_sel` is 4'b0100 for every address.
- R2: While control bit 2 is 0, window 2 matches every address from 0x000000 to 0xFFFFFF, whatever its start and mask registers hold. Once bit 2 is 1, window 2 decodes with its start and mask like the other windows.
- R3: A mask bit of 0 makes its address bits take part in the compare. A mask bit of 1 makes them ignored.
- R4: Window 0 compares A23..A8 against its start register pair: register 1 holds A23..A16 and register 0 holds A15..A8. In its mask (register 2), bits 7..2 cover A20..A15 (bit 7 is A20), bit 1 covers A14..A9 together, and bit 0 covers A8. A7..A0 are never compared.
- R5: Window 1 compares A23..A8 against register 4 (A23..A16) and register 3 (A15..A8). In its mask (register 5), bits 7..2 cover A21..A16 (bit 7 is A21), bit 1 covers A15..A9 together, and bit 0 covers A8.
- R6: Windows 2 and 3 take A23..A16 from their start register (register 6 for window 2, register 8 for window 3). Their start value for A15 is 0, and A14..A0 are never compared. In their mask (register 7 or 9), bit k covers address bit A(15+k).
- R7: Bits above each window's maskable range are always compared: A23..A21 for window 0, A23..A22 for window 1, and A23 for windows 2 and 3.
- R8: Register 10 is the control register. Bit 0 enables window 0, bit 1 enables window 1 and bit 3 enables window 3. While its enable bit is 0, a window never matches.
- R9: `cs_sel` is one-hot or zero. It selects the lowest-numbered window whose `win_hit` bit is set, so window 0 has the highest priority and window 3 the lowest.
- R10: A register write with `wr_en` high is visible on the outputs just after the next rising clock edge and not before. `win_hit` and `cs_sel` follow `bus_addr` with no clock delay.
- R11: Writes to register addresses 11 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | 8 | Register write data |
| bus_addr | input | 24 | Bus address to decode |
| win_hit | output | 4 | Raw match per window, after enable and full-space rules |
| cs_sel | output | 4 | Priority-resolved one-hot chip select |

## Verification
The clocked properties assume that `wr_en`, `wr_addr` and `wr_data` carry known values in every cycle after reset. They also assume that `bus_addr` is settled whenever outputs are sampled at a clock edge. The bench meets both conditions: it drives every input from time zero and changes inputs only at falling edges or shortly after a rising edge. Window contents are kept apart where a check targets one window. The other windows are parked outside the tested addresses by moving window 2's start address or leaving windows disabled. Overlaps are built only on purpose, to exercise the priority.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int ADDR_W    = 24;
  localparam int BYTE_W    = 8;
  localparam int BASE_W    = 2 * BYTE_W;
  localparam int NUM_WIN   = 4;
  localparam int REG_AW    = 4;
  localparam int FINE_LSB  = 8;   // lowest compared bit, windows 0 and 1
  localparam int W0_TOP    = 20;  // highest maskable bit, window 0
  localparam int W1_TOP    = 21;  // highest maskable bit, window 1
  localparam int COARSE_LO = 15;  // lowest compared bit, windows 2 and 3
  localparam int FULL_WIN  = 2;   // window that may span the whole space

  typedef enum int {KIND_W0 = 0, KIND_W1 = 1, KIND_COARSE = 2} win_kind_e;

  typedef enum logic [REG_AW-1:0] {
    RA_W0_LO  = 4'd0,
    RA_W0_HI  = 4'd1,
    RA_W0_MSK = 4'd2,
    RA_W1_LO  = 4'd3,
    RA_W1_HI  = 4'd4,
    RA_W1_MSK = 4'd5,
    RA_W2_HI  = 4'd6,
    RA_W2_MSK = 4'd7,
    RA_W3_HI  = 4'd8,
    RA_W3_MSK = 4'd9,
    RA_CTRL   = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [REG_AW-1:0]                wr_addr,
  input  logic [BYTE_W-1:0]                wr_data,
  output logic [NUM_WIN-1:0][BASE_W-1:0]   base_o,
  output logic [NUM_WIN-1:0][BYTE_W-1:0]   mask_o,
  output logic [NUM_WIN-1:0]               ctrl_o
);
  logic [NUM_WIN-1:0][BASE_W-1:0] base_q;
  logic [NUM_WIN-1:0][BYTE_W-1:0] mask_q;
  logic [NUM_WIN-1:0]             ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= {NUM_WIN{{BYTE_W{1'b1}}}};
      ctrl_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_W0_LO:  base_q[0][BYTE_W-1:0]      <= wr_data;
        RA_W0_HI:  base_q[0][BASE_W-1:BYTE_W] <= wr_data;
        RA_W0_MSK: mask_q[0]                  <= wr_data;
        RA_W1_LO:  base_q[1][BYTE_W-1:0]      <= wr_data;
        RA_W1_HI:  base_q[1][BASE_W-1:BYTE_W] <= wr_data;
        RA_W1_MSK: mask_q[1]                  <= wr_data;
        RA_W2_HI:  base_q[2][BASE_W-1:BYTE_W] <= wr_data;
        RA_W2_MSK: mask_q[2]                  <= wr_data;
        RA_W3_HI:  base_q[3][BASE_W-1:BYTE_W] <= wr_data;
        RA_W3_MSK: mask_q[3]                  <= wr_data;
        RA_CTRL:   ctrl_q                     <= wr_data[NUM_WIN-1:0];
        default: ;
      endcase
    end
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/csel_win_match.sv
module csel_win_match
  import csel_pkg::*;
#(
  parameter int KIND = KIND_COARSE
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic              active_i,
  input  logic              full_i,
  output logic              hit_o
);
  localparam int LOW_W = ADDR_W - BASE_W;

  logic [ADDR_W-1:0] ref_addr;
  logic [ADDR_W-1:0] ign;

  assign ref_addr = {base_i, {LOW_W{1'b0}}};

  generate
    if (KIND == KIND_W0) begin : g_w0
      always_comb begin
        ign                        = '0;
        ign[FINE_LSB-1:0]          = '1;
        ign[FINE_LSB]              = mask_i[0];
        ign[W0_TOP-6:FINE_LSB+1]   = {(W0_TOP-6-FINE_LSB){mask_i[1]}};
        ign[W0_TOP:W0_TOP-5]       = mask_i[7:2];
      end
    end else if (KIND == KIND_W1) begin : g_w1
      always_comb begin
        ign                        = '0;
        ign[FINE_LSB-1:0]          = '1;
        ign[FINE_LSB]              = mask_i[0];
        ign[W1_TOP-6:FINE_LSB+1]   = {(W1_TOP-6-FINE_LSB){mask_i[1]}};
        ign[W1_TOP:W1_TOP-5]       = mask_i[7:2];
      end
    end else begin : g_coarse
      always_comb begin
        ign                                  = '0;
        ign[COARSE_LO-1:0]                   = '1;
        ign[COARSE_LO+BYTE_W-1:COARSE_LO]    = mask_i;
      end
    end
  endgenerate

  assign hit_o = full_i | (active_i & (((addr_i ^ ref_addr) & ~ign) == '0));
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic taken;

  always_comb begin
    gnt_o = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_WIN-1:0]    win_hit,
  output logic [NUM_WIN-1:0]    cs_sel
);
  logic [NUM_WIN-1:0][BASE_W-1:0] base_w;
  logic [NUM_WIN-1:0][BYTE_W-1:0] mask_w;
  logic [NUM_WIN-1:0]             ctrl_q;

  csel_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .base_o  (base_w),
    .mask_o  (mask_w),
    .ctrl_o  (ctrl_q)
  );

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    localparam int KIND = (gi == 0) ? KIND_W0 : ((gi == 1) ? KIND_W1 : KIND_COARSE);
    localparam bit CAN_SPAN = (gi == FULL_WIN);
    logic active, full;
    assign active = CAN_SPAN ? 1'b1 : ctrl_q[gi];
    assign full   = CAN_SPAN ? ~ctrl_q[gi] : 1'b0;

    csel_win_match #(.KIND(KIND)) u_match (
      .addr_i   (bus_addr),
      .base_i   (base_w[gi]),
      .mask_i   (mask_w[gi]),
      .active_i (active),
      .full_i   (full),
      .hit_o    (win_hit[gi])
    );
  end

  csel_prio #(.N(NUM_WIN)) u_prio (
    .req_i (win_hit),
    .gnt_o (cs_sel)
  );
endmodule

// File: rtl/csel_checker.sv
module csel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [3:0] wr_low,
  input logic [3:0] win_hit,
  input logic [3:0] cs_sel,
  input logic [3:0] ctrl
);
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));

  p_sel_in_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel & ~win_hit) == 4'b0000);

  p_w0_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit[0] |-> cs_sel[0]);

  p_w1_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit[1] && !win_hit[0]) |-> cs_sel[1]);

  p_any_hit_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit != 4'b0000) |-> (cs_sel != 4'b0000));

  p_full_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |-> win_hit[2]);

  p_off_w0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !win_hit[0]);

  p_off_w1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |-> !win_hit[1]);

  p_off_w3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[3] |-> !win_hit[3]);

  p_ctrl_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd10) |=> (ctrl == $past(wr_low)));

  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr != 4'd10) |=> $stable(ctrl));
endmodule

bind csel_decoder csel_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_low  (wr_data[3:0]),
  .win_hit (win_hit),
  .cs_sel  (cs_sel),
  .ctrl    (ctrl_q)
);

// File: tb/tb_csel_decoder.sv
module tb_csel_decoder;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] bus_addr = '0;
  logic [3:0]  win_hit;
  logic [3:0]  cs_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  csel_decoder dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bus_addr (bus_addr),
    .win_hit  (win_hit),
    .cs_sel   (cs_sel)
  );

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] ra, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ra;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic chk(input logic [23:0] a, input logic [3:0] eh, input logic [3:0] es,
                     input string tag);
    bus_addr = a;
    #1;
    n_chk++;
    if (win_hit !== eh || cs_sel !== es) begin
      n_fail++;
      $display("FAIL %s addr=%h win_hit=%b exp %b cs_sel=%b exp %b",
               tag, a, win_hit, eh, cs_sel, es);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(24'h000000, 4'b0100, 4'b0100, "R1 R8");
    chk(24'hFFFFFF, 4'b0100, 4'b0100, "R1");
    chk(24'h5A5A5A, 4'b0100, 4'b0100, "R1");
  endtask

  task automatic t_win2();
    do_reset();
    wr(4'd6, 8'h80);
    wr(4'd7, 8'h00);
    chk(24'h000000, 4'b0100, 4'b0100, "R2 unmapped");
    wr(4'd10, 8'h04);
    chk(24'h000000, 4'b0000, 4'b0000, "R2 mapped");
    chk(24'h800000, 4'b0100, 4'b0100, "R6");
    chk(24'h807FFF, 4'b0100, 4'b0100, "R6 low");
    chk(24'h808000, 4'b0000, 4'b0000, "R6 A15");
    chk(24'h810000, 4'b0000, 4'b0000, "R3");
    wr(4'd7, 8'h01);
    chk(24'h808000, 4'b0100, 4'b0100, "R3 A15 masked");
    wr(4'd7, 8'hFF);
    chk(24'hFFFFFF, 4'b0100, 4'b0100, "R6 8MB");
    chk(24'h7FFFFF, 4'b0000, 4'b0000, "R7 A23");
  endtask

  task automatic t_win3();
    do_reset();
    wr(4'd8, 8'h40);
    wr(4'd9, 8'h03);
    wr(4'd10, 8'h08);
    chk(24'h41FFFF, 4'b1100, 4'b0100, "R6 R9");
    wr(4'd6, 8'h00);
    wr(4'd7, 8'h00);
    wr(4'd10, 8'h0C);
    chk(24'h41FFFF, 4'b1000, 4'b1000, "R6 w3");
    chk(24'h420000, 4'b0000, 4'b0000, "R6 w3 A17");
    chk(24'h3FFFFF, 4'b0000, 4'b0000, "R6 w3 below");
  endtask

  task automatic t_win0();
    do_reset();
    wr(4'd0, 8'h34);
    wr(4'd1, 8'h12);
    wr(4'd2, 8'h00);
    chk(24'h123400, 4'b0100, 4'b0100, "R8 w0 off");
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'h00);
    wr(4'd10, 8'h05);
    chk(24'h123400, 4'b0001, 4'b0001, "R4 R8");
    chk(24'h1234FF, 4'b0001, 4'b0001, "R4 low byte");
    chk(24'h123500, 4'b0000, 4'b0000, "R4 A8");
    wr(4'd2, 8'h02);
    chk(24'h127E00, 4'b0001, 4'b0001, "R4 group");
    chk(24'h12B400, 4'b0000, 4'b0000, "R4 A15");
    wr(4'd2, 8'h01);
    chk(24'h123500, 4'b0001, 4'b0001, "R4 A8 masked");
    wr(4'd2, 8'h80);
    chk(24'h023400, 4'b0001, 4'b0001, "R4 A20");
    wr(4'd2, 8'hFF);
    chk(24'h000000, 4'b0001, 4'b0001, "R7 w0");
    chk(24'h1FFFFF, 4'b0001, 4'b0001, "R7 w0 top");
    chk(24'h200000, 4'b0000, 4'b0000, "R7 A21");
  endtask

  task automatic t_win1();
    do_reset();
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'h00);
    wr(4'd3, 8'h78);
    wr(4'd4, 8'h56);
    wr(4'd5, 8'h00);
    wr(4'd10, 8'h06);
    chk(24'h567800, 4'b0010, 4'b0010, "R5");
    chk(24'h56F800, 4'b0000, 4'b0000, "R5 A15");
    wr(4'd5, 8'h02);
    chk(24'h56F800, 4'b0010, 4'b0010, "R5 group");
    chk(24'h567900, 4'b0000, 4'b0000, "R5 A8");
    wr(4'd5, 8'h80);
    chk(24'h767800, 4'b0010, 4'b0010, "R5 A21");
    wr(4'd5, 8'hFF);
    chk(24'h7FFFFF, 4'b0010, 4'b0010, "R7 w1");
    chk(24'h400000, 4'b0010, 4'b0010, "R7 w1 base");
    chk(24'h800000, 4'b0000, 4'b0000, "R7 A23");
    chk(24'h3FFFFF, 4'b0000, 4'b0000, "R7 A22");
  endtask

  task automatic t_priority();
    do_reset();
    wr(4'd10, 8'h0B);
    chk(24'h100000, 4'b1111, 4'b0001, "R9 all");
    chk(24'h300000, 4'b1110, 4'b0010, "R9 w1");
    chk(24'h500000, 4'b1100, 4'b0100, "R9 w2");
    chk(24'h900000, 4'b0100, 4'b0100, "R9 only w2");
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'h00);
    wr(4'd10, 8'h0F);
    chk(24'h500000, 4'b1000, 4'b1000, "R9 w3");
    chk(24'h900000, 4'b0000, 4'b0000, "R9 none");
    chk(24'h100000, 4'b1011, 4'b0001, "R9 gap");
  endtask

  task automatic t_timing();
    do_reset();
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'h00);
    wr(4'd10, 8'h04);
    chk(24'h100000, 4'b0000, 4'b0000, "R10 pre");
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'd10;
    wr_data = 8'h0C;
    chk(24'h100000, 4'b0000, 4'b0000, "R10 before edge");
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    chk(24'h100000, 4'b1000, 4'b1000, "R10 after edge");
    chk(24'h900000, 4'b0000, 4'b0000, "R10 combinational");
  endtask

  task automatic t_unused_regs();
    do_reset();
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'h00);
    wr(4'd10, 8'h04);
    for (int ra = 11; ra < 16; ra++) wr(4'(ra), 8'hFF);
    chk(24'h000000, 4'b0000, 4'b0000, "R11 ctrl kept");
    chk(24'hFF0000, 4'b0100, 4'b0100, "R11 base kept");
    chk(24'hFF8000, 4'b0000, 4'b0000, "R11 mask kept");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    t_reset_state();
    t_win2();
    t_win3();
    t_win0();
    t_win1();
    t_priority();
    t_timing();
    t_unused_regs();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule